// File: doc/BRIEF.md
# Variable-Length Fetch Next-PC Generator

This block computes the address of the next sequential instruction in a fetch stage whose instructions come in four sizes. It receives the current 32-bit program counter and two flags produced once the first instruction byte has been examined: one marks the presence of a register-specifier byte, the other marks a trailing 4-byte constant word. From these it forms the instruction size (1, 2, 5 or 6 bytes) and returns the PC advanced by that size. The block is purely combinational and has no clock or reset.

The add is split so that the flags, which arrive late, only pass through a short path. The PC is divided into a 3-bit low field and a 29-bit high field. The high field is incremented as soon as the PC is valid, in parallel with the instruction-memory read. When the flags settle, a 3-bit adder adds the size to the low field. Its carry-out then picks either the untouched or the incremented high field through a 2:1 select. Because the size never exceeds 6, at most one carry can cross into the high field, so a single precomputed increment always covers the case.

Top module: `fetch_pc_incr`

## Requirements
- R1: The instruction size is 1 byte, plus 1 when `has_regid_i` is high, plus 4 when `has_const_i` is high. From PC 0 the four flag combinations {regid,const} = 00, 10, 01, 11 give `next_pc_o` = 1, 2, 5, 6.
- R2: For every PC and flag combination, `next_pc_o` equals `pc_i` plus the instruction size, modulo 2^32.
- R3: Bits [2:0] of `next_pc_o` equal (`pc_i[2:0]` + size) modulo 8, including when that sum passes 7.
- R4: When `pc_i[2:0]` + size is at most 7, bits [31:3] of `next_pc_o` equal bits [31:3] of `pc_i`.
- R5: When `pc_i[2:0]` + size exceeds 7, bits [31:3] of `next_pc_o` equal `pc_i[31:3]` + 1 modulo 2^29, with the carry running across every bit of the high field.
- R6: A PC near the top of the address space wraps: 0xFFFFFFFF advances to size − 1, and 0xFFFFFFFA with size 6 advances to 0.
- R7: The output follows the inputs without any clock edge. A change on `pc_i` or either flag shows on `next_pc_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| has_regid_i | input | 1 | Instruction carries a register-specifier byte |
| has_const_i | input | 1 | Instruction carries a 4-byte constant word |
| next_pc_o | output | 32 | Address of the next sequential instruction |

## Verification
The bench targets the boundary of the low field. A low-field sum of exactly 8 must carry, while a sum of 7 must not. A design with an off-by-one in the carry or the select would move the high field by one line in one of these cases. It also drives runs of ones across the whole high field, including 0x7FFFFFFF and 0xFFFFFFFF. An incrementer that drops the carry between its internal blocks would show these as wrong upper bits, and a wrong wrap would show a nonzero high field after 0xFFFFFFFF. A sweep over many pseudo-random PCs with every flag combination is compared with a plain 32-bit adder. That comparison exposes a miscoded size, for example a constant word counted as 2 or 8 bytes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int PC_W_DEF    = 32;
    localparam int LOW_W_DEF   = 3;
    localparam int BLK_W_DEF   = 8;

    localparam int OPC_BYTES   = 1;
    localparam int REGID_BYTES = 1;
    localparam int CONST_BYTES = 4;
    localparam int MAX_LEN     = OPC_BYTES + REGID_BYTES + CONST_BYTES;

    typedef struct packed {
        logic has_regid;
        logic has_const;
    } fmt_t;

    function automatic int unsigned size_of(fmt_t f);
        int unsigned n;
        n = OPC_BYTES;
        if (f.has_regid) n = n + REGID_BYTES;
        if (f.has_const) n = n + CONST_BYTES;
        return n;
    endfunction

endpackage

// File: rtl/fpc_len_dec.sv
module fpc_len_dec
    import fpc_pkg::*;
#(
    parameter int LOW_W = LOW_W_DEF
) (
    input  fmt_t             fmt_i,
    output logic [LOW_W-1:0] len_o
);

    always_comb begin
        len_o = LOW_W'(size_of(fmt_i));
    end

    always_comb begin
        if (!$isunknown(fmt_i)) begin
            AST_LEN_NONZERO: assert (len_o != '0)
                else $error("instruction size decoded as zero"); // R1
        end
    end

endmodule

// File: rtl/fpc_low_add.sv
module fpc_low_add #(
    parameter int LOW_W = fpc_pkg::LOW_W_DEF
) (
    input  logic [LOW_W-1:0] pc_lo_i,
    input  logic [LOW_W-1:0] len_i,
    output logic [LOW_W-1:0] sum_o,
    output logic             carry_o
);

    always_comb begin
        {carry_o, sum_o} = {1'b0, pc_lo_i} + {1'b0, len_i};
    end

    always_comb begin
        if (!$isunknown({pc_lo_i, len_i})) begin
            AST_LEN_LEGAL: assert (len_i == LOW_W'(1) || len_i == LOW_W'(2) ||
                                   len_i == LOW_W'(5) || len_i == LOW_W'(6))
                else $error("size %0d outside legal set", len_i); // R1
            AST_SINGLE_CARRY: assert (!carry_o || (sum_o < len_i))
                else $error("low field carried more than once"); // R3
        end
    end

endmodule

// File: rtl/fpc_hi_inc.sv
module fpc_hi_inc #(
    parameter int HIGH_W = fpc_pkg::PC_W_DEF - fpc_pkg::LOW_W_DEF,
    parameter int BLK_W  = fpc_pkg::BLK_W_DEF
) (
    input  logic [HIGH_W-1:0] hi_i,
    output logic [HIGH_W-1:0] inc_o
);

    localparam int NBLK = (HIGH_W + BLK_W - 1) / BLK_W;

    logic [NBLK-1:0] cin;

    assign cin[0] = 1'b1;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam int LO = b * BLK_W;
        localparam int W  = (HIGH_W - LO < BLK_W) ? (HIGH_W - LO) : BLK_W;

        assign inc_o[LO +: W] = hi_i[LO +: W] + W'(cin[b]);

        if (b < NBLK - 1) begin : g_chain
            assign cin[b+1] = cin[b] & (&hi_i[LO +: W]);
        end
    end

    always_comb begin
        if (!$isunknown(hi_i)) begin
            AST_INC_STEP: assert (HIGH_W'(inc_o - hi_i) == HIGH_W'(1))
                else $error("high field increment wrong"); // R5
        end
    end

endmodule

// File: rtl/fpc_hi_sel.sv
module fpc_hi_sel #(
    parameter int HIGH_W = fpc_pkg::PC_W_DEF - fpc_pkg::LOW_W_DEF
) (
    input  logic              sel_i,
    input  logic [HIGH_W-1:0] keep_i,
    input  logic [HIGH_W-1:0] bump_i,
    output logic [HIGH_W-1:0] hi_o
);

    always_comb begin
        hi_o = sel_i ? bump_i : keep_i;
    end

endmodule

// File: rtl/fetch_pc_incr.sv
module fetch_pc_incr
    import fpc_pkg::*;
#(
    parameter int PC_W  = PC_W_DEF,
    parameter int LOW_W = LOW_W_DEF,
    parameter int BLK_W = BLK_W_DEF
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            has_regid_i,
    input  logic            has_const_i,
    output logic [PC_W-1:0] next_pc_o
);

    localparam int HIGH_W = PC_W - LOW_W;

    fmt_t              fmt;
    logic [LOW_W-1:0]  len;
    logic [LOW_W-1:0]  lo_sum;
    logic              lo_carry;
    logic [HIGH_W-1:0] hi_cur;
    logic [HIGH_W-1:0] hi_inc;
    logic [HIGH_W-1:0] hi_next;

    assign fmt.has_regid = has_regid_i;
    assign fmt.has_const = has_const_i;
    assign hi_cur        = pc_i[PC_W-1:LOW_W];

    // Early path: runs off the PC alone.
    fpc_hi_inc #(.HIGH_W(HIGH_W), .BLK_W(BLK_W)) u_hi_inc (
        .hi_i  (hi_cur),
        .inc_o (hi_inc)
    );

    // Late path: waits for the decoded flags.
    fpc_len_dec #(.LOW_W(LOW_W)) u_len_dec (
        .fmt_i (fmt),
        .len_o (len)
    );

    fpc_low_add #(.LOW_W(LOW_W)) u_low_add (
        .pc_lo_i (pc_i[LOW_W-1:0]),
        .len_i   (len),
        .sum_o   (lo_sum),
        .carry_o (lo_carry)
    );

    fpc_hi_sel #(.HIGH_W(HIGH_W)) u_hi_sel (
        .sel_i  (lo_carry),
        .keep_i (hi_cur),
        .bump_i (hi_inc),
        .hi_o   (hi_next)
    );

    assign next_pc_o = {hi_next, lo_sum};

    always_comb begin
        if (!$isunknown({pc_i, has_regid_i, has_const_i})) begin
            AST_KEEP_HIGH: assert (lo_carry || (next_pc_o[PC_W-1:LOW_W] == hi_cur))
                else $error("high field moved without a carry"); // R4
            AST_FULL_SUM: assert (next_pc_o == pc_i + PC_W'(len))
                else $error("next PC differs from full-width sum"); // R2
        end
    end

endmodule

// File: tb/fetch_pc_incr_tb.sv
module fetch_pc_incr_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    localparam int NSWEEP     = 4000;

    // {pc, has_regid, has_const}
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_0003, 1'b1, 1'b1},
        {32'h0000_0007, 1'b0, 1'b0},
        {32'h1234_5674, 1'b0, 1'b1},
        {32'h0000_00FE, 1'b1, 1'b1},
        {32'h0FFF_FFFD, 1'b0, 1'b1},
        {32'hDEAD_BEEF, 1'b1, 1'b0},
        {32'h8000_0002, 1'b1, 1'b1},
        {32'h00FF_FFFC, 1'b0, 1'b1},
        {32'hFFFF_FFF0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic [31:0] pc_i = '0;
    logic        has_regid_i = 1'b0;
    logic        has_const_i = 1'b0;
    logic [31:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_pc_incr u_dut (
        .pc_i        (pc_i),
        .has_regid_i (has_regid_i),
        .has_const_i (has_const_i),
        .next_pc_o   (next_pc_o)
    );

    function automatic logic [31:0] ref_next(logic [31:0] pc, logic r, logic c);
        logic [31:0] sz;
        sz = 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
        return pc + sz;
    endfunction

    task automatic apply(logic [31:0] pc, logic r, logic c);
        @(posedge clk);
        pc_i        <= pc;
        has_regid_i <= r;
        has_const_i <= c;
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc=%h regid=%b const=%b actual=%h expected=%h",
                     req, pc_i, has_regid_i, has_const_i, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Table walk against the plain adder reference (R2)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][33:2], VEC[i][1], VEC[i][0]);
            chk("R2", next_pc_o, ref_next(VEC[i][33:2], VEC[i][1], VEC[i][0]));
        end

        // Initial state from PC 0 and size encoding (R1)
        apply(32'h0, 1'b0, 1'b0); chk("R1", next_pc_o, 32'd1);
        apply(32'h0, 1'b1, 1'b0); chk("R1", next_pc_o, 32'd2);
        apply(32'h0, 1'b0, 1'b1); chk("R1", next_pc_o, 32'd5);
        apply(32'h0, 1'b1, 1'b1); chk("R1", next_pc_o, 32'd6);

        // Low field sum 7: no carry, high unchanged (R4)
        apply(32'h0000_0011, 1'b1, 1'b1);
        chk("R4", {3'b0, next_pc_o[31:3]}, 32'h2);
        chk("R3", {29'b0, next_pc_o[2:0]}, 32'd7);
        apply(32'hFFFF_FFF9, 1'b1, 1'b1);
        chk("R4", next_pc_o, 32'hFFFF_FFFF);

        // Low field sum exactly 8: carry (R3, R5)
        apply(32'h0000_0017, 1'b0, 1'b0);
        chk("R3", {29'b0, next_pc_o[2:0]}, 32'd0);
        chk("R5", {3'b0, next_pc_o[31:3]}, 32'h3);
        apply(32'h0000_001A, 1'b1, 1'b1);
        chk("R3", next_pc_o, 32'h0000_0020);

        // Carry across the whole high field (R5)
        apply(32'h7FFF_FFFF, 1'b1, 1'b0);
        chk("R5", next_pc_o, 32'h8000_0001);
        apply(32'h00FF_FFFE, 1'b0, 1'b1);
        chk("R5", next_pc_o, 32'h0100_0003);

        // Top of address space wraps (R6)
        apply(32'hFFFF_FFFF, 1'b0, 1'b0); chk("R6", next_pc_o, 32'h0);
        apply(32'hFFFF_FFFF, 1'b1, 1'b1); chk("R6", next_pc_o, 32'h5);
        apply(32'hFFFF_FFFA, 1'b1, 1'b1); chk("R6", next_pc_o, 32'h0);

        // Output follows a flag change without a clock edge (R7)
        @(posedge clk);
        pc_i        <= 32'h0000_1000;
        has_regid_i <= 1'b0;
        has_const_i <= 1'b0;
        #1;
        chk("R7", next_pc_o, 32'h0000_1001);
        has_const_i = 1'b1;
        #1;
        chk("R7", next_pc_o, 32'h0000_1005);
        pc_i = 32'h0000_1007;
        #1;
        chk("R7", next_pc_o, 32'h0000_100C);

        // Pseudo-random sweep over all flag combinations (R2)
        for (int k = 0; k < NSWEEP; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            apply(lfsr, k[0], k[1]);
            chk("R2", next_pc_o, ref_next(lfsr, k[0], k[1]));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule